// File: doc/BRIEF.md
# DMA Page Register and Burst Address Generator

This block keeps, for each of four DMA channels, an 8-bit page register and an 8-bit high-page register. Software reaches them through byte-wide page ports. A port number selects a channel through a fixed, irregular mapping, and one select line chooses between the page bank and the high-page bank. Writes to port numbers that map to no channel are dropped. Reads from those ports return zero.

The block also builds the physical address for a transfer burst. A request names a channel and supplies:
- the controller's 16-bit current address for that channel,
- the direction bit from the channel mode,
- the burst position and burst length,
- the channel's base count,
- whether the request comes from the 8-bit or the 16-bit controller.

The block joins the seven low high-page bits, the page byte and the current address into a 31-bit base. It then offsets the base forward or backward. It also computes the full transfer size in bytes. Both results are registered and appear one cycle after the request, together with a valid flag.

Top module: `dma_page_addrgen`

## Requirements
- R1: The three-bit page port number maps to channels as follows: port 7 is channel 0, port 3 is channel 1, port 1 is channel 2 and port 2 is channel 3. A write with `pg_hi`=0 stores the byte in that channel's page register. A write with `pg_hi`=1 stores it in that channel's high-page register.
- R2: A write to port 0, 4, 5 or 6 changes no register in either bank.
- R3: A read of port 0, 4, 5 or 6 returns 0 in either bank. `pg_rdata` is combinational from `pg_port` and `pg_hi`.
- R4: After reset, every page and high-page register reads 0.
- R5: Both registers of every channel read back all 8 bits as written, including high-page bit 7.
- R6: The base address of a request is {high_page[6:0], page[7:0], req_cur_addr[15:0]} (31 bits). High-page bit 7 has no effect on `out_addr`.
- R7: With `req_decr`=0, `out_addr` equals base + req_pos, taken modulo 2^31.
- R8: With `req_decr`=1, `out_addr` equals base − req_pos − req_len, taken modulo 2^31.
- R9: `out_size` equals (req_count + 1) shifted left by 1 when `req_wide`=1, and unshifted when `req_wide`=0. It is 18 bits wide, so a count of 0xFFFF on the 16-bit controller gives 0x20000.
- R10: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. The request uses the page values held before that clock edge, so a page write in the same cycle does not affect that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_wr | input | 1 | Page port write strobe |
| pg_hi | input | 1 | Bank select: 0 page, 1 high page |
| pg_port | input | 3 | Page port number (low three bits) |
| pg_wdata | input | 8 | Write byte |
| pg_rdata | output | 8 | Read byte for the addressed port |
| req_valid | input | 1 | Burst address request strobe |
| req_chan | input | 2 | Channel of the request |
| req_cur_addr | input | 16 | Current address of the channel |
| req_decr | input | 1 | Mode direction bit: 1 decrement |
| req_pos | input | 17 | Burst position in bytes |
| req_len | input | 17 | Burst length in bytes |
| req_count | input | 16 | Channel base count |
| req_wide | input | 1 | 1 when the 16-bit controller issues the request |
| out_valid | output | 1 | Result valid |
| out_addr | output | 31 | Burst start physical address |
| out_size | output | 18 | Full transfer size in bytes |

## Verification
The bench builds the block with its default widths. These are four channels, 8-bit page bytes, a 16-bit current address and 17-bit position and length. With these widths the 31-bit wrap of decrement arithmetic can be reached with small operands. The maximum 18-bit size can be reached with an all-ones count on the wide controller. Random requests across all four channels, both directions and both controllers run against random page contents, including high pages with bit 7 set. Directed cases cover every invalid port in both banks and a page write that collides with a request.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;

  localparam int CH_W   = 2;
  localparam int CH_N   = 1 << CH_W;
  localparam int PORT_W = 3;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
  } port_dec_t;

  // Irregular port-to-channel map; unlisted ports select nothing.
  function automatic port_dec_t decode_port(input logic [PORT_W-1:0] p);
    port_dec_t d;
    d.hit = 1'b1;
    unique case (p)
      3'd7:    d.ch = 2'd0;
      3'd3:    d.ch = 2'd1;
      3'd1:    d.ch = 2'd2;
      3'd2:    d.ch = 2'd3;
      default: begin d.hit = 1'b0; d.ch = 2'd0; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dma_pg_regs.sv
module dma_pg_regs
  import dma_pg_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     sel_hi,
  input  logic [PORT_W-1:0]        port,
  input  logic [PAGE_W-1:0]        wdata,
  output logic [PAGE_W-1:0]        rdata,
  output logic [CH_N*PAGE_W-1:0]   page_flat,
  output logic [CH_N*PAGE_W-1:0]   hpage_flat
);

  port_dec_t   dec;
  logic        wr_hit;
  logic        wr_miss;
  logic [PAGE_W-1:0] page_q  [CH_N];
  logic [PAGE_W-1:0] hpage_q [CH_N];

  assign dec     = decode_port(port);
  assign wr_hit  = wr_en &&  dec.hit;
  assign wr_miss = wr_en && !dec.hit;

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic sel_ch;
    assign sel_ch = wr_hit && (dec.ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        page_q[g]  <= '0;
        hpage_q[g] <= '0;
      end else if (sel_ch) begin
        if (sel_hi) hpage_q[g] <= wdata;
        else        page_q[g]  <= wdata;
      end
    end

    assign page_flat [g*PAGE_W +: PAGE_W] = page_q[g];
    assign hpage_flat[g*PAGE_W +: PAGE_W] = hpage_q[g];
  end

  always_comb begin
    rdata = '0;
    if (dec.hit) rdata = sel_hi ? hpage_q[dec.ch] : page_q[dec.ch];
  end

  a_r4_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (page_flat == '0 && hpage_flat == '0));

  a_r2_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |=> ($stable(page_flat) && $stable(hpage_flat)));

  a_r1_page_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !sel_hi) |=> (page_q[$past(dec.ch)] == $past(wdata)));

  a_r1_hpage_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sel_hi) |=> (hpage_q[$past(dec.ch)] == $past(wdata)));

  a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.hit |-> (rdata == '0));

endmodule

// File: rtl/dma_pg_addrgen.sv
module dma_pg_addrgen #(
  parameter int PAGE_W  = 8,
  parameter int HP_KEEP = 7,
  parameter int CUR_W   = 16,
  parameter int XFER_W  = 17,
  parameter int CNT_W   = 16,
  localparam int PHYS_W = HP_KEEP + PAGE_W + CUR_W,
  localparam int SIZE_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] hpage,
  input  logic [CUR_W-1:0]  cur,
  input  logic              decr,
  input  logic [XFER_W-1:0] pos,
  input  logic [XFER_W-1:0] len,
  input  logic [CNT_W-1:0]  count,
  input  logic              wide,
  output logic              out_valid,
  output logic [PHYS_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size
);

  function automatic logic [PHYS_W-1:0] phys_base(
    input logic [PAGE_W-1:0] hp, input logic [PAGE_W-1:0] pg,
    input logic [CUR_W-1:0] ca);
    return {hp[HP_KEEP-1:0], pg, ca};
  endfunction

  function automatic logic [PHYS_W-1:0] burst_start(
    input logic [PHYS_W-1:0] b, input logic dn,
    input logic [XFER_W-1:0] p, input logic [XFER_W-1:0] l);
    logic [PHYS_W-1:0] pe, le;
    pe = PHYS_W'(p);
    le = PHYS_W'(l);
    return dn ? (b - pe - le) : (b + pe);
  endfunction

  function automatic logic [SIZE_W-1:0] xfer_size(
    input logic [CNT_W-1:0] c, input logic w);
    logic [SIZE_W-1:0] n;
    n = SIZE_W'(c) + SIZE_W'(1);
    return w ? (n << 1) : n;
  endfunction

  logic [PHYS_W-1:0] base_w;
  logic [PHYS_W-1:0] start_w;
  logic [SIZE_W-1:0] size_w;

  assign base_w  = phys_base(hpage, page, cur);
  assign start_w = burst_start(base_w, decr, pos, len);
  assign size_w  = xfer_size(count, wide);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_size  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= start_w;
        out_size <= size_w;
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  a_r7_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !decr && pos == '0) |=> (out_addr[CUR_W-1:0] == $past(cur)));

  a_r9_wide_even: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wide) |=> (out_size[0] == 1'b0));

  a_r6_page_field: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pos == '0 && len == '0) |=>
      (out_addr[CUR_W +: PAGE_W] == $past(page)));

endmodule

// File: rtl/dma_page_addrgen.sv
module dma_page_addrgen
  import dma_pg_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int HP_KEEP = 7,
  parameter int CUR_W   = 16,
  parameter int XFER_W  = 17,
  parameter int CNT_W   = 16,
  localparam int PHYS_W = HP_KEEP + PAGE_W + CUR_W,
  localparam int SIZE_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_wr,
  input  logic              pg_hi,
  input  logic [2:0]        pg_port,
  input  logic [PAGE_W-1:0] pg_wdata,
  output logic [PAGE_W-1:0] pg_rdata,
  input  logic              req_valid,
  input  logic [1:0]        req_chan,
  input  logic [CUR_W-1:0]  req_cur_addr,
  input  logic              req_decr,
  input  logic [XFER_W-1:0] req_pos,
  input  logic [XFER_W-1:0] req_len,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_wide,
  output logic              out_valid,
  output logic [PHYS_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size
);

  logic [CH_N*PAGE_W-1:0] page_flat;
  logic [CH_N*PAGE_W-1:0] hpage_flat;
  logic [PAGE_W-1:0]      chan_page;
  logic [PAGE_W-1:0]      chan_hpage;

  dma_pg_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (pg_wr),
    .sel_hi     (pg_hi),
    .port       (pg_port),
    .wdata      (pg_wdata),
    .rdata      (pg_rdata),
    .page_flat  (page_flat),
    .hpage_flat (hpage_flat)
  );

  assign chan_page  = page_flat [req_chan*PAGE_W +: PAGE_W];
  assign chan_hpage = hpage_flat[req_chan*PAGE_W +: PAGE_W];

  dma_pg_addrgen #(
    .PAGE_W (PAGE_W),
    .HP_KEEP(HP_KEEP),
    .CUR_W  (CUR_W),
    .XFER_W (XFER_W),
    .CNT_W  (CNT_W)
  ) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .page      (chan_page),
    .hpage     (chan_hpage),
    .cur       (req_cur_addr),
    .decr      (req_decr),
    .pos       (req_pos),
    .len       (req_len),
    .count     (req_count),
    .wide      (req_wide),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_size  (out_size)
  );

endmodule

// File: tb/dma_page_addrgen_tb.sv
module dma_page_addrgen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_wr = 1'b0, pg_hi = 1'b0;
  logic [2:0]  pg_port = '0;
  logic [7:0]  pg_wdata = '0;
  logic [7:0]  pg_rdata;
  logic        req_valid = 1'b0;
  logic [1:0]  req_chan = '0;
  logic [15:0] req_cur_addr = '0;
  logic        req_decr = 1'b0;
  logic [16:0] req_pos = '0, req_len = '0;
  logic [15:0] req_count = '0;
  logic        req_wide = 1'b0;
  logic        out_valid;
  logic [30:0] out_addr;
  logic [17:0] out_size;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] m_page [4];
  logic [7:0] m_hpage[4];

  always #2.5 clk = ~clk;

  dma_page_addrgen u_dut (
    .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_hi(pg_hi), .pg_port(pg_port),
    .pg_wdata(pg_wdata), .pg_rdata(pg_rdata), .req_valid(req_valid),
    .req_chan(req_chan), .req_cur_addr(req_cur_addr), .req_decr(req_decr),
    .req_pos(req_pos), .req_len(req_len), .req_count(req_count),
    .req_wide(req_wide), .out_valid(out_valid), .out_addr(out_addr),
    .out_size(out_size)
  );

  // Bench view of the port map: -1 means no channel.
  function automatic int chan_of(input int p);
    case (p)
      7: return 0;
      3: return 1;
      1: return 2;
      2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int port_of(input int c);
    case (c)
      0: return 7;
      1: return 3;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic longint exp_addr(input int c, input longint cur,
                                      input bit dn, input longint p, input longint l);
    longint b;
    b = (longint'(m_hpage[c] % 128) * 64'h100_0000) + (longint'(m_page[c]) * 64'h1_0000) + cur;
    if (dn) return (b - p - l) & 64'h7FFF_FFFF;
    return (b + p) & 64'h7FFF_FFFF;
  endfunction

  function automatic longint exp_size(input longint cnt, input bit w);
    return w ? (cnt + 1) * 2 : (cnt + 1);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  task automatic pg_write(input int p, input bit hi, input logic [7:0] d);
    @(negedge clk);
    pg_wr = 1'b1; pg_port = 3'(p); pg_hi = hi; pg_wdata = d;
    @(negedge clk);
    pg_wr = 1'b0;
    if (chan_of(p) >= 0) begin
      if (hi) m_hpage[chan_of(p)] = d;
      else    m_page[chan_of(p)]  = d;
    end
  endtask

  task automatic pg_read_check(input int p, input bit hi, input string req);
    logic [7:0] e;
    pg_port = 3'(p); pg_hi = hi;
    #1;
    if (chan_of(p) < 0) e = 8'h00;
    else e = hi ? m_hpage[chan_of(p)] : m_page[chan_of(p)];
    check(pg_rdata == e, req, pg_rdata, e);
  endtask

  task automatic request(input int c, input logic [15:0] cur, input bit dn,
                         input logic [16:0] p, input logic [16:0] l,
                         input logic [15:0] cnt, input bit w, input string req);
    longint ea, es;
    ea = exp_addr(c, cur, dn, p, l);
    es = exp_size(cnt, w);
    @(negedge clk);
    req_valid = 1'b1; req_chan = 2'(c); req_cur_addr = cur; req_decr = dn;
    req_pos = p; req_len = l; req_count = cnt; req_wide = w;
    @(negedge clk);
    req_valid = 1'b0;
    check(out_valid == 1'b1, "R10", out_valid, 1);
    check(out_addr == 31'(ea), req, out_addr, ea);
    check(out_size == 18'(es), "R9", out_size, es);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin m_page[i] = 0; m_hpage[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: reset state of all registers; R3 zero on invalid ports
    for (int p = 0; p < 8; p++) begin
      pg_read_check(p, 0, "R4");
      pg_read_check(p, 1, "R4");
    end
    check(out_valid == 1'b0, "R10", out_valid, 0);

    // R1/R5: distinct bytes on each valid port, both banks
    for (int c = 0; c < 4; c++) begin
      pg_write(port_of(c), 0, 8'(8'h10 + c));
      pg_write(port_of(c), 1, 8'(8'hF0 + c));
    end
    for (int c = 0; c < 4; c++) begin
      pg_read_check(port_of(c), 0, "R1");
      pg_read_check(port_of(c), 1, "R5");
    end

    // R2/R3: writes to invalid ports change nothing
    pg_write(0, 0, 8'hAA); pg_write(4, 1, 8'hBB);
    pg_write(5, 0, 8'hCC); pg_write(6, 1, 8'hDD);
    for (int p = 0; p < 8; p++) begin
      pg_read_check(p, 0, "R2");
      pg_read_check(p, 1, "R3");
    end

    // R6: high-page bit 7 set but not seen in the address
    request(0, 16'h1234, 0, 17'd0, 17'd0, 16'd0, 0, "R6");
    // R1: each channel's page shows in the address
    for (int c = 0; c < 4; c++) request(c, 16'h0000, 0, 17'd0, 17'd5, 16'd7, 1, "R1");

    // R8: decrement wraps below zero
    pg_write(7, 0, 8'h00); pg_write(7, 1, 8'h80);
    request(0, 16'h0000, 1, 17'd1, 17'd0, 16'd0, 0, "R8");
    request(0, 16'h0003, 1, 17'd2, 17'd4, 16'd1, 0, "R8");
    // R7: increment wraps past the top
    pg_write(7, 0, 8'hFF); pg_write(7, 1, 8'h7F);
    request(0, 16'hFFFF, 0, 17'h1FFFF, 17'd0, 16'd0, 0, "R7");
    // R9: largest size on each controller
    request(1, 16'h0100, 0, 17'd0, 17'd0, 16'hFFFF, 1, "R9");
    request(1, 16'h0100, 0, 17'd0, 17'd0, 16'hFFFF, 0, "R9");

    // R10: one-cycle valid, then low
    @(negedge clk);
    check(out_valid == 1'b0, "R10", out_valid, 0);

    // R10: page write colliding with a request uses the old page
    begin
      longint ea;
      ea = exp_addr(2, 16'h0040, 0, 17'd0, 17'd0);
      @(negedge clk);
      pg_wr = 1'b1; pg_port = 3'd1; pg_hi = 1'b0; pg_wdata = 8'h5A;
      req_valid = 1'b1; req_chan = 2'd2; req_cur_addr = 16'h0040; req_decr = 1'b0;
      req_pos = '0; req_len = '0; req_count = '0; req_wide = 1'b0;
      @(negedge clk);
      pg_wr = 1'b0; req_valid = 1'b0;
      m_page[2] = 8'h5A;
      check(out_addr == 31'(ea), "R10", out_addr, ea);
      pg_read_check(1, 0, "R1");
    end

    // Random mix of writes and requests
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        pg_write(int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)), 8'($urandom));
      end else begin
        int rc;
        rc = int'($urandom_range(0, 3));
        if ($urandom_range(0, 1) == 1)
          request(rc, 16'($urandom), bit'($urandom_range(0, 1)), 17'($urandom),
                  17'($urandom), 16'($urandom), bit'($urandom_range(0, 1)), "R7");
        else
          request(rc, 16'($urandom), 1'b1, 17'($urandom), 17'($urandom),
                  16'($urandom), bit'($urandom_range(0, 1)), "R8");
      end
    end
    for (int p = 0; p < 8; p++) begin
      pg_read_check(p, 0, "R5");
      pg_read_check(p, 1, "R5");
    end

    done = 1;
    summary();
  end

endmodule